// File: doc/BRIEF.md
# Immediate Exclusive-OR Execution Unit

This unit carries out one exclusive-OR-with-immediate instruction taken from a stream of 16-bit instruction words. A pulse on `start` presents the opcode. The unit checks that the opcode belongs to it and reads the operand size, the destination mode and the destination register from it. It then pulls one or two immediate extension words through a request/acknowledge fetch port. The destination operand is read through a request/acknowledge operand port, XORed with the immediate at the selected size, and written back with a single-cycle write strobe.

When the write-back is done, the unit updates the negative, zero, overflow and carry flags. It also reports how many cycles the instruction costs and how far the program counter advances. The surrounding core handles effective-address generation, bus arbitration and exceptions. It passes in the address cost as plain inputs and serves the operand port.

Top module: `xori_exec`

## Requirements
- R1: An opcode is accepted when bits 15..8 equal 8'h0A and the size field in bits 7..6 is 0 (byte), 1 (word) or 2 (long). Bits 5..3 (mode) and 2..0 (register) appear on `opnd_mode` and `opnd_reg` while the operand is requested.
- R2: A byte operation fetches exactly one extension word and uses only its low 8 bits. It changes only bits 7..0 of the destination, keeps bits 31..8 of the value read, and reports a program-counter step of 2.
- R3: A word operation fetches exactly one extension word. It changes only bits 15..0 of the destination, keeps bits 31..16, and reports a step of 2.
- R4: A long operation fetches exactly two extension words, the first forming bits 31..16 of the immediate and the second bits 15..0. It reports a step of 4.
- R5: Overflow and carry are both 0 after every completed operation.
- R6: After completion, negative equals the result bit at the operand size's top (bit 7, 15 or 31). Zero is 1 exactly when the sized result bits are all 0, whatever the preserved upper bits hold.
- R7: For byte and word operations the reported cost is 8 when the mode is 0. Otherwise it is 12 plus `ea_cost`.
- R8: For long operations the reported cost is 16 when the mode is 0. Otherwise it is 20 plus `ea_cost_long`.
- R9: A size field of 3, or a wrong upper opcode byte, raises `illegal` for one cycle, one cycle after `start`. In that case there is no fetch request, no operand request, no write and no `done`, and the flags keep their values.
- R10: `done` is a one-cycle pulse in the cycle right after the write strobe. `fetch_req` stays low from `done` until the next accepted `start`.
- R11: A `start` that arrives while an operation is in progress is ignored, and the running operation finishes with its own opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with `opcode` |
| opcode | input | 16 | Instruction word |
| ea_cost | input | 8 | Address cost added for byte/word, non-register |
| ea_cost_long | input | 8 | Address cost added for long, non-register |
| fetch_req | output | 1 | Request next extension word |
| fetch_ack | input | 1 | Extension word valid on `fetch_word` |
| fetch_word | input | 16 | Extension word |
| opnd_req | output | 1 | Request destination operand read |
| opnd_ack | input | 1 | Operand valid on `opnd_rdata` |
| opnd_rdata | input | 32 | Destination operand value |
| opnd_mode | output | 3 | Destination mode field |
| opnd_reg | output | 3 | Destination register field |
| opnd_we | output | 1 | Write strobe for `opnd_wdata` |
| opnd_wdata | output | 32 | Result to write back |
| done | output | 1 | Operation complete |
| illegal | output | 1 | Opcode rejected |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| cycles | output | 9 | Cycle cost, valid with `done` |
| pc_step | output | 3 | Program-counter advance, valid with `done` |

## Verification
The assertions assume that the core raises each acknowledge only while the matching request is high, and that it holds `ea_cost` inputs steady around the `start` that is accepted. The bench acts as that core. It samples requests on the falling edge and answers with a one-cycle acknowledge. It changes the cost inputs only while the unit is idle. The one deliberate protocol stress is a second `start` pulse while the fetch port is waiting. The unit must ignore that pulse.

// File: rtl/xori_pkg.sv
package xori_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } opsize_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FHI,
    ST_FLO,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } xstate_e;

  localparam logic [7:0] XORI_MATCH = 8'h0A;
endpackage

// File: rtl/xori_decode.sv
module xori_decode
  import xori_pkg::*;
#(
  parameter int OPC_W = 16
) (
  input  logic [OPC_W-1:0] opcode,
  output opsize_e          size,
  output logic [2:0]       mode,
  output logic [2:0]       reg_idx,
  output logic             legal
);
  always_comb begin
    size    = opsize_e'(opcode[7:6]);
    mode    = opcode[5:3];
    reg_idx = opcode[2:0];
    legal   = (opcode[OPC_W-1:8] == XORI_MATCH) && (opcode[7:6] != 2'd3);
  end
endmodule

// File: rtl/xori_ctrl.sv
module xori_ctrl
  import xori_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       legal,
  input  opsize_e    size_in,
  input  logic [2:0] mode_in,
  input  logic [2:0] reg_in,
  input  logic       fetch_ack,
  input  logic       opnd_ack,
  output logic       accept,
  output opsize_e    size_q,
  output logic [2:0] mode_q,
  output logic [2:0] reg_q,
  output logic       fetch_req,
  output logic       fetch_hi_ld,
  output logic       fetch_lo_ld,
  output logic       opnd_req,
  output logic       opnd_cap,
  output logic       wr_en,
  output logic       done,
  output logic       illegal
);
  xstate_e state_q, state_d;
  logic    illegal_d;

  always_comb begin
    accept    = (state_q == ST_IDLE) && start && legal;
    illegal_d = (state_q == ST_IDLE) && start && !legal;
    state_d   = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_FHI;
      ST_FHI:   if (fetch_ack) state_d = (size_q == SZ_LONG) ? ST_FLO : ST_READ;
      ST_FLO:   if (fetch_ack) state_d = ST_READ;
      ST_READ:  if (opnd_ack) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      illegal <= 1'b0;
    end else begin
      state_q <= state_d;
      illegal <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_BYTE;
      mode_q <= 3'd0;
      reg_q  <= 3'd0;
    end else if (accept) begin
      size_q <= size_in;
      mode_q <= mode_in;
      reg_q  <= reg_in;
    end
  end

  always_comb begin
    fetch_req   = (state_q == ST_FHI) || (state_q == ST_FLO);
    fetch_hi_ld = (state_q == ST_FHI) && fetch_ack;
    fetch_lo_ld = (state_q == ST_FLO) && fetch_ack;
    opnd_req    = (state_q == ST_READ);
    opnd_cap    = (state_q == ST_READ) && opnd_ack;
    wr_en       = (state_q == ST_WRITE);
    done        = (state_q == ST_DONE);
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done);
  // R10
  no_fetch_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !fetch_req);
  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!fetch_req && !opnd_req && !wr_en && !done));
  // R4
  second_fetch_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_lo_ld |-> (size_q == SZ_LONG));
endmodule

// File: rtl/xori_datapath.sv
module xori_datapath
  import xori_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  opsize_e           size_in,
  input  logic [2:0]        mode_in,
  input  logic [COST_W-1:0] ea_cost,
  input  logic [COST_W-1:0] ea_cost_long,
  input  opsize_e           size_q,
  input  logic              fetch_hi_ld,
  input  logic              fetch_lo_ld,
  input  logic [DATA_W/2-1:0] fetch_word,
  input  logic              opnd_cap,
  input  logic [DATA_W-1:0] opnd_rdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] wdata,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic [COST_W:0]   cycles,
  output logic [2:0]        pc_step
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] imm_q, imm_d, opnd_q;
  logic [COST_W:0]   cost_d;
  logic [2:0]        step_d;
  logic              n_d, z_d;

  // immediate assembly
  always_comb begin
    imm_d = imm_q;
    if (fetch_hi_ld) begin
      if (size_q == SZ_LONG) imm_d[DATA_W-1:HALF_W] = fetch_word;
      else                   imm_d[HALF_W-1:0]      = fetch_word;
    end else if (fetch_lo_ld) begin
      imm_d[HALF_W-1:0] = fetch_word;
    end
  end

  // sized XOR with upper-bit preservation and flag evaluation
  always_comb begin
    wdata = opnd_q;
    n_d   = 1'b0;
    z_d   = 1'b0;
    case (size_q)
      SZ_BYTE: begin
        wdata[BYTE_W-1:0] = opnd_q[BYTE_W-1:0] ^ imm_q[BYTE_W-1:0];
        n_d = wdata[BYTE_W-1];
        z_d = (wdata[BYTE_W-1:0] == '0);
      end
      SZ_WORD: begin
        wdata[HALF_W-1:0] = opnd_q[HALF_W-1:0] ^ imm_q[HALF_W-1:0];
        n_d = wdata[HALF_W-1];
        z_d = (wdata[HALF_W-1:0] == '0);
      end
      default: begin
        wdata = opnd_q ^ imm_q;
        n_d   = wdata[DATA_W-1];
        z_d   = (wdata == '0);
      end
    endcase
  end

  // cost and program-counter step, latched on acceptance
  always_comb begin
    if (size_in == SZ_LONG) begin
      step_d = 3'd4;
      cost_d = (mode_in == 3'd0) ? (COST_W+1)'(16)
                                 : {1'b0, ea_cost_long} + (COST_W+1)'(20);
    end else begin
      step_d = 3'd2;
      cost_d = (mode_in == 3'd0) ? (COST_W+1)'(8)
                                 : {1'b0, ea_cost} + (COST_W+1)'(12);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imm_q <= '0;
    else if (fetch_hi_ld || fetch_lo_ld) imm_q <= imm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opnd_q <= '0;
    else if (opnd_cap) opnd_q <= opnd_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycles  <= '0;
      pc_step <= 3'd0;
    end else if (accept) begin
      cycles  <= cost_d;
      pc_step <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else if (wr_en) begin
      flag_n <= n_d;
      flag_z <= z_d;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end
  end

  // R5
  vc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!flag_v && !flag_c));
  // R2
  byte_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size_q == SZ_BYTE) |-> (wdata[DATA_W-1:BYTE_W] == opnd_q[DATA_W-1:BYTE_W]));
  // R3
  word_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size_q == SZ_WORD) |-> (wdata[DATA_W-1:HALF_W] == opnd_q[DATA_W-1:HALF_W]));
endmodule

// File: rtl/xori_exec.sv
module xori_exec
  import xori_pkg::*;
#(
  parameter int OPC_W  = 16,
  parameter int DATA_W = 32,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [COST_W-1:0] ea_cost,
  input  logic [COST_W-1:0] ea_cost_long,
  output logic              fetch_req,
  input  logic              fetch_ack,
  input  logic [OPC_W-1:0]  fetch_word,
  output logic              opnd_req,
  input  logic              opnd_ack,
  input  logic [DATA_W-1:0] opnd_rdata,
  output logic [2:0]        opnd_mode,
  output logic [2:0]        opnd_reg,
  output logic              opnd_we,
  output logic [DATA_W-1:0] opnd_wdata,
  output logic              done,
  output logic              illegal,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic [COST_W:0]   cycles,
  output logic [2:0]        pc_step
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  opsize_e    dec_size, size_q;
  logic [2:0] dec_mode, dec_reg;
  logic       dec_legal, accept;
  logic       fetch_hi_ld, fetch_lo_ld, opnd_cap;

  xori_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode (opcode),
    .size   (dec_size),
    .mode   (dec_mode),
    .reg_idx(dec_reg),
    .legal  (dec_legal)
  );

  xori_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .legal      (dec_legal),
    .size_in    (dec_size),
    .mode_in    (dec_mode),
    .reg_in     (dec_reg),
    .fetch_ack  (fetch_ack),
    .opnd_ack   (opnd_ack),
    .accept     (accept),
    .size_q     (size_q),
    .mode_q     (opnd_mode),
    .reg_q      (opnd_reg),
    .fetch_req  (fetch_req),
    .fetch_hi_ld(fetch_hi_ld),
    .fetch_lo_ld(fetch_lo_ld),
    .opnd_req   (opnd_req),
    .opnd_cap   (opnd_cap),
    .wr_en      (opnd_we),
    .done       (done),
    .illegal    (illegal)
  );

  xori_datapath #(.DATA_W(DATA_W), .COST_W(COST_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .accept      (accept),
    .size_in     (dec_size),
    .mode_in     (dec_mode),
    .ea_cost     (ea_cost),
    .ea_cost_long(ea_cost_long),
    .size_q      (size_q),
    .fetch_hi_ld (fetch_hi_ld),
    .fetch_lo_ld (fetch_lo_ld),
    .fetch_word  (fetch_word),
    .opnd_cap    (opnd_cap),
    .opnd_rdata  (opnd_rdata),
    .wr_en       (opnd_we),
    .wdata       (opnd_wdata),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_v      (flag_v),
    .flag_c      (flag_c),
    .cycles      (cycles),
    .pc_step     (pc_step)
  );

  // R9
  illegal_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    illegal |-> $stable({flag_n, flag_z, flag_v, flag_c}));
  // R11
  busy_no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fetch_req || opnd_req || opnd_we) |=> !illegal);
  // R10
  exclusive_port_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(fetch_req && (opnd_req || opnd_we)));
endmodule

// File: tb/xori_exec_tb_top.sv
module xori_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = 16'h0;
  logic [7:0]  ea_cost = 8'd5;
  logic [7:0]  ea_cost_long = 8'd9;
  logic        fetch_req, fetch_ack = 1'b0;
  logic [15:0] fetch_word = 16'h0;
  logic        opnd_req, opnd_ack = 1'b0;
  logic [31:0] opnd_rdata = 32'h0;
  logic [2:0]  opnd_mode, opnd_reg;
  logic        opnd_we;
  logic [31:0] opnd_wdata;
  logic        done, illegal, flag_n, flag_z, flag_v, flag_c;
  logic [8:0]  cycles;
  logic [2:0]  pc_step;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xori_exec dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .ea_cost(ea_cost), .ea_cost_long(ea_cost_long),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_word(fetch_word),
    .opnd_req(opnd_req), .opnd_ack(opnd_ack), .opnd_rdata(opnd_rdata),
    .opnd_mode(opnd_mode), .opnd_reg(opnd_reg),
    .opnd_we(opnd_we), .opnd_wdata(opnd_wdata),
    .done(done), .illegal(illegal),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .cycles(cycles), .pc_step(pc_step)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vector table: opcode, word0, word1, operand read, expected write,
  // expected {n,z}, expected cycles, expected step, expected fetch count
  localparam int NV = 7;
  localparam logic [15:0] V_OPC [NV] = '{16'h0A03, 16'h0A11, 16'h0A47, 16'h0A68, 16'h0A82, 16'h0A9C, 16'h0A80};
  localparam logic [15:0] V_W0  [NV] = '{16'hFF5A, 16'h0077, 16'h8001, 16'h1234, 16'hDEAD, 16'h1234, 16'h0000};
  localparam logic [15:0] V_W1  [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hBEEF, 16'h5678, 16'h0001};
  localparam logic [31:0] V_RD  [NV] = '{32'h123456A5, 32'hAAAABB77, 32'h00000001, 32'hFFFF1234,
                                         32'h00000000, 32'h12345678, 32'h7FFFFFFF};
  localparam logic [31:0] V_WD  [NV] = '{32'h123456FF, 32'hAAAABB00, 32'h00008000, 32'hFFFF0000,
                                         32'hDEADBEEF, 32'h00000000, 32'h7FFFFFFE};
  localparam logic [1:0]  V_NZ  [NV] = '{2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b00};
  localparam logic [8:0]  V_CYC [NV] = '{9'd8, 9'd17, 9'd8, 9'd17, 9'd16, 9'd29, 9'd16};
  localparam logic [2:0]  V_PC  [NV] = '{3'd2, 3'd2, 3'd2, 3'd2, 3'd4, 3'd4, 3'd4};
  localparam int          V_NF  [NV] = '{1, 1, 1, 1, 2, 2, 2};

  int          got_nf;
  logic [31:0] got_wd;
  logic [2:0]  got_mode, got_reg;
  bit          got_done;

  task automatic run_op(input logic [15:0] opc, input logic [15:0] w0, input logic [15:0] w1,
                        input logic [31:0] rd, input bit poke);
    bit poked = 1'b0;
    got_nf = 0; got_wd = '0; got_done = 1'b0; got_mode = '0; got_reg = '0;
    @(negedge clk); start = 1'b1; opcode = opc;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      fetch_ack = 1'b0; opnd_ack = 1'b0; start = 1'b0;
      if (done) begin got_done = 1'b1; break; end
      if (fetch_req) begin
        if (poke && !poked) begin
          poked = 1'b1; start = 1'b1; opcode = 16'h0A80;
        end else begin
          fetch_ack = 1'b1; fetch_word = (got_nf == 0) ? w0 : w1; got_nf++;
        end
      end
      if (opnd_req) begin
        opnd_ack = 1'b1; opnd_rdata = rd; got_mode = opnd_mode; got_reg = opnd_reg;
      end
      if (opnd_we) got_wd = opnd_wdata;
      @(negedge clk);
    end
    fetch_ack = 1'b0; opnd_ack = 1'b0; start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state (R10, R5)
    chk(!fetch_req && !opnd_req && !opnd_we && !done && !illegal, "R10 reset idle",
        {27'd0, fetch_req, opnd_req, opnd_we, done, illegal}, 32'd0);
    chk({flag_n, flag_z, flag_v, flag_c} == 4'b0, "R5 reset flags",
        {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      run_op(V_OPC[v], V_W0[v], V_W1[v], V_RD[v], 1'b0);
      chk(got_done, "R10 done seen", {31'd0, got_done}, 32'd1);
      chk(got_mode == V_OPC[v][5:3] && got_reg == V_OPC[v][2:0], "R1 mode/reg",
          {26'd0, got_mode, got_reg}, {26'd0, V_OPC[v][5:0]});
      chk(got_wd == V_WD[v], "R2 R3 R4 write data", got_wd, V_WD[v]);
      chk(got_nf == V_NF[v], "R4 fetch count", got_nf, V_NF[v]);
      chk({flag_n, flag_z} == V_NZ[v], "R6 n/z", {30'd0, flag_n, flag_z}, {30'd0, V_NZ[v]});
      chk(!flag_v && !flag_c, "R5 v/c clear", {30'd0, flag_v, flag_c}, 32'd0);
      chk(cycles == V_CYC[v], (V_PC[v] == 3'd4) ? "R8 cost" : "R7 cost", {23'd0, cycles}, {23'd0, V_CYC[v]});
      chk(pc_step == V_PC[v], "R2 R4 pc step", {29'd0, pc_step}, {29'd0, V_PC[v]});
      @(negedge clk);
      chk(!done, "R10 done one cycle", {31'd0, done}, 32'd0);
      for (int k = 0; k < 3; k++) begin
        chk(!fetch_req, "R10 no fetch after done", {31'd0, fetch_req}, 32'd0);
        @(negedge clk);
      end
    end

    // R9: size field 3 rejected, flags kept (last vector left n=0,z=0)
    run_op(16'h0A00, 16'h0001, 16'h0000, 32'h00000001, 1'b0);
    chk({flag_n, flag_z} == 2'b01, "R9 setup flags", {30'd0, flag_n, flag_z}, 32'd1);
    @(negedge clk); start = 1'b1; opcode = 16'h0AC3;
    @(negedge clk); start = 1'b0;
    chk(illegal, "R9 illegal size 3", {31'd0, illegal}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      chk(!fetch_req && !opnd_req && !opnd_we && !done, "R9 quiet after illegal",
          {28'd0, fetch_req, opnd_req, opnd_we, done}, 32'd0);
      if (k == 1) chk(!illegal, "R9 illegal one cycle", {31'd0, illegal}, 32'd0);
      @(negedge clk);
    end
    chk({flag_n, flag_z} == 2'b01, "R9 flags kept", {30'd0, flag_n, flag_z}, 32'd1);
    // R9: wrong upper byte rejected
    @(negedge clk); start = 1'b1; opcode = 16'h0B00;
    @(negedge clk); start = 1'b0;
    chk(illegal, "R9 illegal upper byte", {31'd0, illegal}, 32'd1);
    @(negedge clk);
    chk(!fetch_req, "R9 no fetch upper byte", {31'd0, fetch_req}, 32'd0);

    // R11: second start during fetch wait ignored
    run_op(16'h0A03, 16'hAB11, 16'h0000, 32'hFFFFFF00, 1'b1);
    chk(got_nf == 1, "R11 one fetch", got_nf, 32'd1);
    chk(got_wd == 32'hFFFFFF11, "R11 byte result kept", got_wd, 32'hFFFFFF11);
    chk(cycles == 9'd8 && pc_step == 3'd2, "R11 cost/step kept",
        {20'd0, cycles, pc_step}, {20'd0, 9'd8, 3'd2});

    // R7/R8 with different cost inputs
    ea_cost = 8'd255; ea_cost_long = 8'd255;
    run_op(16'h0A50, 16'h00FF, 16'h0000, 32'h0, 1'b0);
    chk(cycles == 9'd267, "R7 max ea cost", {23'd0, cycles}, 32'd267);
    run_op(16'h0A90, 16'h0000, 16'h0001, 32'h0, 1'b0);
    chk(cycles == 9'd275, "R8 max ea cost", {23'd0, cycles}, 32'd275);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule